// File: doc/BRIEF.md
# Oscillator Lock Phase/Frequency Comparator

This block steers an external voltage-controlled crystal oscillator so that it stays locked to the 4.096 MHz main reference clock. Both oscillator signals enter as raw levels. They are sampled by a fast core clock, and their rising edges are counted by two modulo dividers. The reference is divided by 8. The oscillator is divided by 30 for a 15.36 MHz part or by 32 for a 16.384 MHz part, so both paths meet at a common 512 kHz comparison rate.

A three-state phase/frequency comparator looks at the rising edges of the two divided signals and drives one error pin. It pushes the pin high while the reference edge is ahead and low while the oscillator edge is ahead. It releases the pin when the two edges are in phase. The pin is split into a level and an output enable, and the pad cell and the loop filter sit outside the block.

A change of the ratio select restarts both dividers and releases the pin, so a half-finished count cannot produce a false correction.

Top module: `vcxo_lock_cmp`

## Requirements
- R1: While `rst_ni` is low at a clock edge, and in the cycles after its release until the first comparison edge, `err_oe_o` and `err_o` are both 0.
- R2: `err_o` is 1 only while `err_oe_o` is 1; a released pin always presents level 0.
- R3: The reference path produces one comparison edge on every 8th rising edge of `ref_clk_i`, counted from reset or from the last ratio change. The first such edge comes on the 8th rising edge.
- R4: A reference comparison edge that arrives while the pin is released drives the pin high (`err_oe_o`=1, `err_o`=1).
- R5: The oscillator path produces one comparison edge on every P-th rising edge of `vcxo_clk_i`, where P=30 when `sel_p32_i`=0 and P=32 when `sel_p32_i`=1. Such an edge that arrives while the pin is released drives the pin low (`err_oe_o`=1, `err_o`=0).
- R6: A comparison edge from the opposite path to the one that is driving the pin releases it (`err_oe_o`=0).
- R7: Comparison edges from both paths in the same core cycle leave the pin state unchanged.
- R8: Any change of `sel_p32_i` releases the pin and restarts both divider counts from zero.
- R9: A further comparison edge from the path that is already driving the pin keeps the pin driven at the same level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core sampling clock, well above twice the oscillator frequency |
| rst_ni | input | 1 | Synchronous active-low reset |
| ref_clk_i | input | 1 | 4.096 MHz reference clock level |
| vcxo_clk_i | input | 1 | Oscillator clock level (15.36 or 16.384 MHz) |
| sel_p32_i | input | 1 | Oscillator divide ratio select: 0 = 30, 1 = 32 |
| err_o | output | 1 | Error level for the pad: 1 = speed up, 0 = slow down |
| err_oe_o | output | 1 | Pad output enable; 0 leaves the error pin in high impedance |

## Verification
A divider that counts wrongly shows at the ports as the first drive of the pin arriving one or more input edges early or late. The bench finds this by walking the edges one at a time, so an off-by-one count is visible on the 8th, 30th or 32nd edge. A comparator stuck in a wrong state shows as a pin that stays driven after an opposite edge, or as a coincident pair that moves the pin; the fault appears within a handful of core cycles of that edge. A ratio change that fails to clear a count shows as the pin firing before a full fresh count of edges. Free-running sweeps with a fast and a slow oscillator check that the pin spends most of its driven time at the correcting level.

// File: rtl/vcxo_cmp_pkg.sv
// Package: shared types for the oscillator lock comparator.
// Assumes: nothing beyond IEEE 1800-2017.
package vcxo_cmp_pkg;

    // Comparator state: which side, if any, is driving the error pin.
    typedef enum logic [1:0] {
        PFD_IDLE = 2'b00,
        PFD_UP   = 2'b01,
        PFD_DN   = 2'b10
    } pfd_state_e;

endpackage

// File: rtl/vcxo_edge_sync.sv
// Module: vcxo_edge_sync
// Samples an asynchronous clock level with a flop chain in the core clock
// domain and emits a one-cycle strobe on each rising edge.
// Assumes: STAGES >= 2 and a core clock above twice the input frequency.
module vcxo_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic lvl_i,
    output logic rise_o
);

    logic [STAGES-1:0] chain_q;
    logic              last_q;

    // Shift the level through the chain and keep the previous settled value.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            chain_q <= '0;
            last_q  <= 1'b0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], lvl_i};
            last_q  <= chain_q[STAGES-1];
        end
    end

    assign rise_o = chain_q[STAGES-1] & ~last_q;

endmodule

// File: rtl/vcxo_mod_div.sv
// Module: vcxo_mod_div
// Modulo counter of input edge strobes with a run-time ratio (last_i + 1).
// Its output is high for the first half of the count, so it rises once per
// full count, on the edge that wraps the counter to zero.
// Assumes: last_i >= 1; clr_i forces the count back to zero at once.
module vcxo_mod_div #(
    parameter int W = 5
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         clr_i,
    input  logic         tick_i,
    input  logic [W-1:0] last_i,
    output logic         div_o
);

    logic [W-1:0] cnt_q;

    // Count strobes, wrap at the ratio, restart on reset or clear.
    always_ff @(posedge clk_i) begin
        if (!rst_ni || clr_i) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            cnt_q <= (cnt_q == last_i) ? '0 : cnt_q + W'(1);
        end
    end

    // Near-even duty: high for counts 0 .. last/2.
    assign div_o = (cnt_q <= (last_i >> 1));

endmodule

// File: rtl/vcxo_pfd.sv
// Module: vcxo_pfd
// Three-state phase/frequency comparator on the rising edges of two
// divided clocks. Reference ahead drives high, oscillator ahead drives low,
// an edge from the lagging side releases the pin.
// Assumes: both divided inputs are in the core clock domain; clr_i marks a
// cycle in which the dividers are being restarted (their outputs return high).
module vcxo_pfd
    import vcxo_cmp_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic clr_i,
    input  logic ref_div_i,
    input  logic vco_div_i,
    output logic err_o,
    output logic err_oe_o
);

    pfd_state_e state_q, state_d;
    logic       ref_prev_q, vco_prev_q;
    logic       ref_rise, vco_rise;

    assign ref_rise = ref_div_i & ~ref_prev_q;
    assign vco_rise = vco_div_i & ~vco_prev_q;

    // Next state from the pair of rising edges seen this cycle.
    always_comb begin
        state_d = state_q;
        if (clr_i) begin
            state_d = PFD_IDLE;
        end else if (ref_rise && !vco_rise) begin
            state_d = (state_q == PFD_DN) ? PFD_IDLE : PFD_UP;
        end else if (vco_rise && !ref_rise) begin
            state_d = (state_q == PFD_UP) ? PFD_IDLE : PFD_DN;
        end
    end

    // Hold state and previous levels; a restart presets the levels high
    // so the divider returning to count zero is not taken as an edge.
    always_ff @(posedge clk_i) begin
        if (!rst_ni || clr_i) begin
            state_q    <= PFD_IDLE;
            ref_prev_q <= 1'b1;
            vco_prev_q <= 1'b1;
        end else begin
            state_q    <= state_d;
            ref_prev_q <= ref_div_i;
            vco_prev_q <= vco_div_i;
        end
    end

    assign err_o    = (state_q == PFD_UP);
    assign err_oe_o = (state_q != PFD_IDLE);

endmodule

// File: rtl/vcxo_lock_cmp.sv
// Module: vcxo_lock_cmp (top)
// Divides the reference by REF_DIV and the oscillator by VCO_DIV_A or
// VCO_DIV_B, then compares the two divided clocks and drives the error pin
// as a level plus an output enable for an external tri-state pad.
// Assumes: clk_i is faster than twice the oscillator frequency; sel_p32_i
// is quasi-static and any change of it restarts the comparison.
module vcxo_lock_cmp #(
    parameter int REF_DIV     = 8,
    parameter int VCO_DIV_A   = 30,
    parameter int VCO_DIV_B   = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic ref_clk_i,
    input  logic vcxo_clk_i,
    input  logic sel_p32_i,
    output logic err_o,
    output logic err_oe_o
);

    localparam int VCO_MAX = (VCO_DIV_A > VCO_DIV_B) ? VCO_DIV_A : VCO_DIV_B;
    localparam int REF_W   = $clog2(REF_DIV);
    localparam int VCO_W   = $clog2(VCO_MAX);

    logic             ref_tick, vco_tick;
    logic             ref_div_w, vco_div_w;
    logic             sel_q;
    logic             ratio_clr;
    logic [REF_W-1:0] ref_last;
    logic [VCO_W-1:0] vco_last;

    // Remember the ratio select to spot a change.
    always_ff @(posedge clk_i) begin
        sel_q <= sel_p32_i;
    end

    assign ratio_clr = rst_ni && (sel_p32_i != sel_q);
    assign ref_last  = REF_W'(REF_DIV - 1);
    assign vco_last  = sel_p32_i ? VCO_W'(VCO_DIV_B - 1) : VCO_W'(VCO_DIV_A - 1);

    vcxo_edge_sync #(.STAGES(SYNC_STAGES)) u_ref_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .lvl_i  (ref_clk_i),
        .rise_o (ref_tick)
    );

    vcxo_edge_sync #(.STAGES(SYNC_STAGES)) u_vco_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .lvl_i  (vcxo_clk_i),
        .rise_o (vco_tick)
    );

    vcxo_mod_div #(.W(REF_W)) u_ref_div (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (ratio_clr),
        .tick_i (ref_tick),
        .last_i (ref_last),
        .div_o  (ref_div_w)
    );

    vcxo_mod_div #(.W(VCO_W)) u_vco_div (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (ratio_clr),
        .tick_i (vco_tick),
        .last_i (vco_last),
        .div_o  (vco_div_w)
    );

    vcxo_pfd u_pfd (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .clr_i     (ratio_clr),
        .ref_div_i (ref_div_w),
        .vco_div_i (vco_div_w),
        .err_o     (err_o),
        .err_oe_o  (err_oe_o)
    );

endmodule

// File: rtl/vcxo_lock_cmp_chk.sv
// Module: vcxo_lock_cmp_chk
// Checker bound to vcxo_lock_cmp: relates the divided clocks, the ratio
// restart and the error pin over time.
// Assumes: connected through the bind below to the top's internal nets.
module vcxo_lock_cmp_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic clr,
    input logic ref_div,
    input logic vco_div,
    input logic err_o,
    input logic err_oe_o
);

    assert_level_gated_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_o |-> err_oe_o);

    assert_ref_drives_up_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($rose(ref_div) && !$past(clr) && !$rose(vco_div) && !clr && !err_oe_o)
        |=> (err_oe_o && err_o));

    assert_vco_drives_dn_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($rose(vco_div) && !$past(clr) && !$rose(ref_div) && !clr && !err_oe_o)
        |=> (err_oe_o && !err_o));

    assert_opposite_releases_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($rose(vco_div) && !$past(clr) && !$rose(ref_div) && !clr && err_oe_o && err_o)
        |=> !err_oe_o);

    assert_coincident_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($rose(ref_div) && $rose(vco_div) && !$past(clr) && !clr)
        |=> (err_oe_o == $past(err_oe_o) && err_o == $past(err_o)));

    assert_ratio_release_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr |=> (!err_oe_o && ref_div && vco_div));

    assert_same_side_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($rose(ref_div) && !$past(clr) && !$rose(vco_div) && !clr && err_oe_o && err_o)
        |=> (err_oe_o && err_o));

endmodule

bind vcxo_lock_cmp vcxo_lock_cmp_chk u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr      (ratio_clr),
    .ref_div  (ref_div_w),
    .vco_div  (vco_div_w),
    .err_o    (err_o),
    .err_oe_o (err_oe_o)
);

// File: tb/vcxo_lock_cmp_bench.sv
// Bench: vcxo_lock_cmp_bench
// Walks input edges one at a time and checks the pin after each, with the
// expected state derived from edge counts; then runs free-running sweeps.
module vcxo_lock_cmp_bench;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_clk = 1'b0;
    logic vco_clk = 1'b0;
    logic sel32 = 1'b0;
    logic err, err_oe;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    vcxo_lock_cmp u_vcxo_lock_cmp (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .ref_clk_i  (ref_clk),
        .vcxo_clk_i (vco_clk),
        .sel_p32_i  (sel32),
        .err_o      (err),
        .err_oe_o   (err_oe)
    );

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // Compare {oe, level} against the expected pair.
    task automatic chk(input string req, input logic exp_oe, input logic exp_lvl);
        n_chk++;
        if (err_oe !== exp_oe || err !== exp_lvl) begin
            n_bad++;
            $display("FAIL %s: oe/level actual %b/%b expected %b/%b",
                     req, err_oe, err, exp_oe, exp_lvl);
        end
    endtask

    // Issue rising edges; the last edges of both inputs share a cycle.
    task automatic edges(input int nr, input int nv);
        int m = (nr > nv) ? nr : nv;
        for (int i = 0; i < m; i++) begin
            ref_clk = (i >= m - nr);
            vco_clk = (i >= m - nv);
            step(3);
            ref_clk = 1'b0;
            vco_clk = 1'b0;
            step(3);
        end
        step(6);
    endtask

    // Free-running inputs with given half periods; count driven cycles.
    task automatic free_run(input int hr, input int hv, input int n,
                            output int up, output int dn);
        int cr = 0;
        int cv = 0;
        up = 0;
        dn = 0;
        for (int i = 0; i < n; i++) begin
            cr++;
            cv++;
            if (cr == hr) begin ref_clk = ~ref_clk; cr = 0; end
            if (cv == hv) begin vco_clk = ~vco_clk; cv = 0; end
            step(1);
            if (err_oe && err) up++;
            if (err_oe && !err) dn++;
        end
        ref_clk = 1'b0;
        vco_clk = 1'b0;
        step(8);
    endtask

    initial begin
        int up, dn;
        step(5);
        chk("R1 in reset", 1'b0, 1'b0);
        rst_n = 1'b1;
        step(4);
        chk("R1 after release", 1'b0, 1'b0);

        // R3/R4: reference path fires on the 8th edge only.
        for (int k = 1; k <= 8; k++) begin
            edges(1, 0);
            chk($sformatf("R3 R4 ref edge %0d", k), k == 8, k == 8);
        end
        // R9: another full reference count keeps the pin high.
        edges(8, 0);
        chk("R9 repeated up", 1'b1, 1'b1);

        // R5/R6 with P=30: pin held until the 30th oscillator edge releases it.
        for (int k = 1; k <= 30; k++) begin
            edges(0, 1);
            chk($sformatf("R6 vco edge %0d under up", k), k < 30, k < 30);
        end
        for (int k = 1; k <= 30; k++) begin
            edges(0, 1);
            chk($sformatf("R5 P30 vco edge %0d", k), k == 30, 1'b0);
        end
        edges(8, 0);
        chk("R6 ref releases down", 1'b0, 1'b0);

        // R7: coincident comparison edges leave the pin released.
        edges(8, 30);
        chk("R7 coincident from idle", 1'b0, 1'b0);

        // R5 with P=32 after a ratio change.
        sel32 = 1'b1;
        step(6);
        chk("R8 release on select", 1'b0, 1'b0);
        for (int k = 1; k <= 32; k++) begin
            edges(0, 1);
            chk($sformatf("R5 P32 vco edge %0d", k), k == 32, 1'b0);
        end

        // R7 while driving low: coincident edges keep the low drive.
        edges(8, 32);
        chk("R7 coincident under down", 1'b1, 1'b0);

        // R8: partial count discarded and pin released on a ratio change.
        edges(5, 0);
        chk("R8 partial count no event", 1'b1, 1'b0);
        sel32 = 1'b0;
        step(6);
        chk("R8 release on change", 1'b0, 1'b0);
        edges(7, 0);
        chk("R8 restart needs 8 edges", 1'b0, 1'b0);
        edges(1, 0);
        chk("R8 fires on fresh 8th", 1'b1, 1'b1);

        // Sweeps: fast oscillator pushes low, slow oscillator pushes high.
        sel32 = 1'b0;
        step(2);
        sel32 = 1'b1;
        step(2);
        sel32 = 1'b0;
        step(4);
        free_run(4, 1, 4000, up, dn);
        n_chk++;
        if (!(dn > up)) begin
            n_bad++;
            $display("FAIL R5 fast vco: down %0d up %0d expected down > up", dn, up);
        end
        sel32 = 1'b1;
        step(6);
        free_run(4, 2, 4000, up, dn);
        n_chk++;
        if (!(up > dn)) begin
            n_bad++;
            $display("FAIL R4 slow vco: up %0d down %0d expected up > down", up, dn);
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule